// File: doc/BRIEF.md
# DSP Program Sequencer and Branch Unit

This block is the control-flow engine of a small audio DSP. It holds the program counter and decodes each 16-bit instruction fetched at that address. Every cycle it works out the next address. Data-path instructions, data moves and no-ops step the counter by one. Jumps, a single-level call and return, and a jump to the upper half of the accumulator load a new address. Conditional branches test the flags that the ALU produced.

Three configuration registers are loaded by control opcodes: a 6-bit register base, a 3-bit register map and a 5-bit operand mask. A halt opcode stops the run. A start pulse clears all state and begins again at address 0. The ALU, the memories and operand fetching sit outside this block. The fetched instruction, the flags and the accumulator's upper half come in as ports.

Top module: `dsp_seq`

## Requirements
- R1: After reset, or in the cycle after a start pulse, the PC is 0, the done output is low, and the return register, register base, register map and operand mask are all 0. A start pulse takes priority over the current instruction.
- R2: An instruction advances the PC by one, wrapping from 2^AW-1 to 0, when it is any of the following:
  - an instruction with bit 15 clear;
  - an instruction in the range 0x9000–0x9FFF;
  - a special operation (bits 15:10 = 100000) with bits 9:7 equal to 0 or 6.
- R3: Opcodes with bits 15:10 equal to 100001 or 100011 set the PC to bits 9:0.
- R4: Opcode bits 15:10 = 100010 is a call. It stores PC+1 in the return register and sets the PC to bits 9:0. A special operation with bits 9:7 = 4 sets the PC to the return register.
- R5: A special operation with bits 9:7 = 1 sets the PC to acc_hi[9:0].
- R6: The special operations with bits 9:7 = 2, 3 and 5 load, in turn, the register base from bits 5:0, the register map from bits 2:0 and the operand mask from bits 4:0. Each of the three registers is unchanged by every other instruction.
- R7: A special operation with bits 9:7 = 7 raises done in the next cycle and leaves the PC at its address. While done is high, every instruction is ignored: the PC and all registers hold, until a start pulse.
- R8: An instruction with bit 15 set and bits 14:13 not both zero is a conditional branch. Its condition code is bits 14:10 and its target is bits 9:0. If the condition holds, the PC becomes the target; otherwise it becomes PC+1. The conditions are:
  - Codes 0x08, 0x0C, 0x10 and 0x14 are always false.
  - Single and paired flag tests: 0x09 Over, 0x0A Neg, 0x0B Neg&Over, 0x0D Zero, 0x0E Carry, 0x0F Carry&Zero.
  - Negated tests: 0x11 !Over, 0x12 !Neg, 0x13 !Neg&!Over, 0x15 !Zero, 0x16 !Carry, 0x17 !Carry&!Zero.
  - Upper range: 0x18 Neg≠Over, 0x1A (Neg≠Over)|Zero, 0x1C Carry&!Zero, 0x1E Exact.
  - Each odd code from 0x19 to 0x1F is the inverse of the even code below it.
- R9: The next_pc output always equals the PC value that the coming clock edge will load, when start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous run restart pulse |
| instr | input | 16 | Instruction fetched at pc |
| acc_hi | input | 16 | Accumulator bits 31:16 |
| f_zero | input | 1 | Zero flag |
| f_neg | input | 1 | Negative flag |
| f_carry | input | 1 | Carry flag |
| f_over | input | 1 | Overflow flag |
| f_exact | input | 1 | Exact flag |
| pc | output | AW | Current program counter |
| next_pc | output | AW | Address for the next cycle |
| ret_pc | output | AW | Return register |
| done | output | 1 | Run halted |
| reg_base | output | 6 | Register base |
| reg_map | output | 3 | Register map |
| op_mask | output | 5 | Operand mask |

## Verification
The bench builds the block with its default AW of 10, so the top address 1023 can be reached by one jump. This brings the wrap to 0 within a single step. Because the address space is this small, each of the 24 branch condition codes can be swept against all 32 flag combinations, with a check of both the taken and the fall-through address. Directed sequences cover call and return, the jump to the accumulator, the configuration loads, and the halt-then-ignore behaviour.

// File: rtl/dsp_seq.sv
module dsp_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic [15:0]   acc_hi,
  input  logic          f_zero,
  input  logic          f_neg,
  input  logic          f_carry,
  input  logic          f_over,
  input  logic          f_exact,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] ret_pc,
  output logic          done,
  output logic [5:0]    reg_base,
  output logic [2:0]    reg_map,
  output logic [4:0]    op_mask
);

  logic [4:0]    cc;
  logic          cc_hit;
  logic          no_ov;
  logic [AW-1:0] pc_inc;
  logic          ld_base, ld_map, ld_mask, ld_ret, halt;

  assign cc     = instr[14:10];
  assign no_ov  = f_neg ^ f_over;
  assign pc_inc = pc + 1'b1;

  always_comb begin
    logic upper;
    case (cc[2:1])
      2'd0:    upper = no_ov;
      2'd1:    upper = no_ov | f_zero;
      2'd2:    upper = f_carry & ~f_zero;
      default: upper = f_exact;
    endcase
    case (cc)
      5'h09:   cc_hit = f_over;
      5'h0A:   cc_hit = f_neg;
      5'h0B:   cc_hit = f_neg & f_over;
      5'h0D:   cc_hit = f_zero;
      5'h0E:   cc_hit = f_carry;
      5'h0F:   cc_hit = f_carry & f_zero;
      5'h11:   cc_hit = ~f_over;
      5'h12:   cc_hit = ~f_neg;
      5'h13:   cc_hit = ~f_neg & ~f_over;
      5'h15:   cc_hit = ~f_zero;
      5'h16:   cc_hit = ~f_carry;
      5'h17:   cc_hit = ~f_carry & ~f_zero;
      default: cc_hit = cc[4] & cc[3] & (upper ^ cc[0]);
    endcase
  end

  always_comb begin
    next_pc = pc_inc;
    ld_base = 1'b0;
    ld_map  = 1'b0;
    ld_mask = 1'b0;
    ld_ret  = 1'b0;
    halt    = 1'b0;
    if (done) begin
      next_pc = pc;
    end else if (instr[15]) begin
      if (instr[14:13] != 2'b00) begin
        if (cc_hit) next_pc = instr[AW-1:0];
      end else begin
        case (instr[12:10])
          3'b000: begin
            case (instr[9:7])
              3'd1: next_pc = acc_hi[AW-1:0];
              3'd2: ld_base = 1'b1;
              3'd3: ld_map  = 1'b1;
              3'd4: next_pc = ret_pc;
              3'd5: ld_mask = 1'b1;
              3'd7: begin halt = 1'b1; next_pc = pc; end
              default: ;
            endcase
          end
          3'b001, 3'b011: next_pc = instr[AW-1:0];
          3'b010: begin ld_ret = 1'b1; next_pc = instr[AW-1:0]; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ret_pc   <= '0;
      done     <= 1'b0;
      reg_base <= '0;
      reg_map  <= '0;
      op_mask  <= '0;
    end else if (start) begin
      pc       <= '0;
      ret_pc   <= '0;
      done     <= 1'b0;
      reg_base <= '0;
      reg_map  <= '0;
      op_mask  <= '0;
    end else begin
      pc <= next_pc;
      if (ld_ret)  ret_pc   <= pc_inc;
      if (halt)    done     <= 1'b1;
      if (ld_base) reg_base <= instr[5:0];
      if (ld_map)  reg_map  <= instr[2:0];
      if (ld_mask) op_mask  <= instr[4:0];
    end
  end

endmodule

module dsp_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [15:0]   instr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ret_pc,
  input logic          done,
  input logic [5:0]    reg_base
);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pc == '0) && !done && (ret_pc == '0) && (reg_base == '0));

  a_r2_alu_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done && !instr[15]) |=> pc == AW'($past(pc) + 1'b1));

  a_r3_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done && instr[15:10] == 6'b100001) |=> pc == $past(instr[AW-1:0]));

  a_r4_call_saves: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done && instr[15:10] == 6'b100010) |=> ret_pc == AW'($past(pc) + 1'b1));

  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(pc) && $stable(reg_base) && $stable(ret_pc));

  a_r7_halt_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done && instr[15:7] == 9'b100000111) |=> done && $stable(pc));

endmodule

bind dsp_seq dsp_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
  .ret_pc(ret_pc), .done(done), .reg_base(reg_base)
);

// File: tb/dsp_seq_tb_top.sv
`timescale 1ns/1ps
module dsp_seq_tb_top;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] instr = 16'h0000, acc_hi = 16'h0000;
  logic f_zero = 0, f_neg = 0, f_carry = 0, f_over = 0, f_exact = 0;
  logic [AW-1:0] pc, next_pc, ret_pc;
  logic done;
  logic [5:0] reg_base;
  logic [2:0] reg_map;
  logic [4:0] op_mask;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dsp_seq #(.AW(AW)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins);
    instr = ins;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
  endtask

  function automatic bit cond_ref(input int c, input bit z, n, cy, o, e);
    bit r;
    case (c)
      9: r = o;   10: r = n;   11: r = n && o;   13: r = z;   14: r = cy;   15: r = cy && z;
      17: r = !o; 18: r = !n;  19: r = !n && !o; 21: r = !z;  22: r = !cy;  23: r = !cy && !z;
      24: r = n != o;          25: r = n == o;
      26: r = (n != o) || z;   27: r = !((n != o) || z);
      28: r = cy && !z;        29: r = !(cy && !z);
      30: r = e;               31: r = !e;
      default: r = 0;
    endcase
    return r;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    chk("R1 pc", pc, 0); chk("R1 done", done, 0); chk("R1 ret", ret_pc, 0);
    chk("R1 base", reg_base, 0); chk("R1 map", reg_map, 0); chk("R1 mask", op_mask, 0);

    step(16'h1234); chk("R2 alu", pc, 1);
    step(16'h7FFF); chk("R2 alu", pc, 2);
    step(16'h9000); chk("R2 move", pc, 3);
    step(16'h9FFF); chk("R2 move", pc, 4);
    step(16'h8000); chk("R2 nop0", pc, 5);
    step(16'h8300); chk("R2 nop6", pc, 6);
    instr = 16'h87FF; #0.1; chk("R9 next_pc", next_pc, 10'h3FF);
    step(16'h87FF); chk("R3 jump", pc, 10'h3FF);
    step(16'h0000); chk("R2 wrap", pc, 0);
    step(16'h8D55); chk("R3 jump alt", pc, 10'h155);

    step(16'h8500); chk("R3 jump", pc, 10'h100);
    step(16'h8A00); chk("R4 call pc", pc, 10'h200); chk("R4 call ret", ret_pc, 10'h101);
    step(16'h0001); chk("R2 step", pc, 10'h201);
    step(16'h8200); chk("R4 return", pc, 10'h101);

    acc_hi = 16'hABCD;
    step(16'h8080); chk("R5 jump acc", pc, 10'h3CD);

    step(16'h812A); chk("R6 base", reg_base, 6'h2A); chk("R6 map kept", reg_map, 0);
    step(16'h8185); chk("R6 map", reg_map, 5); chk("R6 base kept", reg_base, 6'h2A);
    step(16'h82B3); chk("R6 mask", op_mask, 5'h13); chk("R6 map kept", reg_map, 5);
    step(16'h817F); chk("R6 base", reg_base, 6'h3F);
    step(16'h8400); chk("R6 kept on jump", reg_base, 6'h3F); chk("R6 mask kept", op_mask, 5'h13);

    step(16'h8420);
    step(16'h8380); chk("R7 done", done, 1); chk("R7 pc held", pc, 10'h020);
    step(16'h8455); chk("R7 jump ignored", pc, 10'h020);
    step(16'h8101); chk("R7 load ignored", reg_base, 6'h3F);
    step(16'h8A10); chk("R7 call ignored", ret_pc, 10'h101); chk("R7 still done", done, 1);
    restart();
    chk("R1 restart pc", pc, 0); chk("R1 restart done", done, 0);
    chk("R1 restart base", reg_base, 0); chk("R1 restart ret", ret_pc, 0);
    chk("R1 restart mask", op_mask, 0);

    for (int c = 8; c < 32; c++) begin
      for (int f = 0; f < 32; f++) begin
        int exp_pc;
        restart();
        {f_exact, f_over, f_carry, f_neg, f_zero} = f[4:0];
        instr = 16'h8000 | 16'(c << 10) | 16'h2A5;
        exp_pc = cond_ref(c, f[0], f[1], f[2], f[3], f[4]) ? 'h2A5 : 1;
        #0.1;
        chk($sformatf("R9 cond %0h flags %0h", c, f), next_pc, exp_pc);
        step(instr);
        chk($sformatf("R8 cond %0h flags %0h", c, f), pc, exp_pc);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule